// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the header that a master node places on a LIN bus at the start of every frame. Software, or a neighbouring bus interface, writes an identifier byte through a one-cycle strobe. The block then drives a single serial line through a fixed three-part sequence. First comes a long dominant break with its recessive delimiter. Next is a synchronisation character carrying 0x55. Last is a character carrying the identifier. Each bit lasts one period of an externally supplied baud tick, so the block has no rate divider of its own.

A ready flag tells the writer when the identifier has been committed to the line. While an enable bit is set, the same flag also drives an interrupt request. The two top identifier bits can optionally be replaced by the LIN protection bits, which are computed from the lower six bits. A write that arrives while a header is being sent is discarded, so the field on the line is never disturbed.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no header is in progress, `txd` is 1 (recessive) and `tx_ready` is 1.
- R2: A header begins with 13 consecutive bit times of `txd`=0, followed by one bit time of `txd`=1.
- R3: After the delimiter, the sync character is sent: one 0 start bit, then the eight bits of 0x55 starting with bit 0, then one 1 stop bit.
- R4: The identifier character follows: one 0 start bit, then identifier bits 0 to 7 starting with bit 0, then one 1 stop bit. When `cfg_auto_parity`=0, the eight bits are the byte written.
- R5: A pulse on `id_wr` while idle captures `id_data` and `cfg_auto_parity`. It drives `tx_ready` to 0 in the next cycle. The first break bit starts in the cycle after the first `baud_tick` that the block samples after the write.
- R6: `tx_ready` returns to 1 in the cycle in which the identifier start bit appears on `txd`. It stays 1 until the next accepted write.
- R7: `irq` is 1 exactly when `tx_ready` is 1 and `cfg_irq_en` is 1.
- R8: When `cfg_auto_parity`=1, identifier bit 6 is sent as ID0^ID1^ID2^ID4 and bit 7 as NOT(ID1^ID3^ID4^ID5). Bits 0 to 5 are sent as written.
- R9: An `id_wr` pulse that arrives from the accepting write up to and including the cycle of the final stop-bit tick is ignored. It changes neither the bits sent nor `tx_ready`.
- R10: `txd` changes only in the cycle after a sampled `baud_tick`, so each bit lasts exactly one tick period. After the identifier stop bit, the line returns to idle at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| id_wr | input | 1 | Identifier write strobe |
| id_data | input | 8 | Identifier value written |
| cfg_auto_parity | input | 1 | Replace bits 7:6 with protection bits |
| cfg_irq_en | input | 1 | Interrupt mask enable |
| txd | output | 1 | Serial line, 1 = recessive |
| tx_ready | output | 1 | Identifier committed / ready for next write |
| irq | output | 1 | Interrupt request |

## Verification
If the bit counter loses its place, the header gets a break of the wrong length or a shifted sync pattern. Either fault shows on `txd` within one tick period of the slip. If the state machine re-arms on a late write, it starts a second break right away, which the line sampler sees at the next tick. An identifier register that is overwritten during a header shows a wrong byte in the last character. A ready flag set at the wrong moment is caught by the comparison on every cycle, in the exact cycle where it goes wrong.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } hdr_state_e;

  localparam int unsigned LIN_ID_W = 8;

  // Protected identifier: low six bits kept, two check bits on top.
  function automatic logic [LIN_ID_W-1:0] lin_protect(input logic [LIN_ID_W-1:0] raw);
    logic p_lo;
    logic p_hi;
    p_lo = raw[0] ^ raw[1] ^ raw[2] ^ raw[4];
    p_hi = ~(raw[1] ^ raw[3] ^ raw[4] ^ raw[5]);
    return {p_hi, p_lo, raw[5:0]};
  endfunction

endpackage

// File: rtl/lin_id_parity.sv
module lin_id_parity
  import lin_hdr_pkg::*;
(
  input  logic [LIN_ID_W-1:0] raw_id,
  input  logic                auto_en,
  output logic [LIN_ID_W-1:0] line_id
);

  logic [LIN_ID_W-1:0] protected_id;

  always_comb begin
    protected_id = lin_protect(raw_id);
    line_id      = auto_en ? protected_id : raw_id;
  end

  // R8: bits 5:0 always pass through unchanged
  always_comb begin
    assert_low_bits_kept_R8: assert (line_id[5:0] == raw_id[5:0]);
  end

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int unsigned TOTAL_BITS = 34,
  parameter int unsigned ID_START   = 24,
  parameter int unsigned CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             id_wr,
  output logic             accept,
  output logic             shift_en,
  output logic             go_idle,
  output logic [CNT_W-1:0] nxt_idx,
  output logic             busy,
  output logic             tx_ready
);

  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] READY_IDX = CNT_W'(ID_START);

  hdr_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rdy_d    = rdy_q;
    accept   = 1'b0;
    shift_en = 1'b0;
    go_idle  = 1'b0;
    nxt_idx  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (id_wr) begin
          accept = 1'b1;
          st_d   = ST_ARM;
          rdy_d  = 1'b0;
        end
      end
      ST_ARM: begin
        if (baud_tick) begin
          st_d     = ST_SEND;
          cnt_d    = '0;
          shift_en = 1'b1;
          nxt_idx  = '0;
        end
      end
      ST_SEND: begin
        if (baud_tick) begin
          shift_en = 1'b1;
          if (cnt_q == LAST_IDX) begin
            st_d    = ST_IDLE;
            go_idle = 1'b1;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            nxt_idx = cnt_q + 1'b1;
            if (cnt_q + 1'b1 == READY_IDX) begin
              rdy_d = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign tx_ready = rdy_q;

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND) |-> (cnt_q <= LAST_IDX));

  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && id_wr) |=> (st_q != ST_ARM));

  assert_arm_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM && !baud_tick) |=> (st_q == ST_ARM));

endmodule

// File: rtl/lin_hdr_bitgen.sv
module lin_hdr_bitgen #(
  parameter int unsigned         BREAK_BITS = 13,
  parameter logic [7:0]          SYNC_CHAR  = 8'h55,
  parameter int unsigned         CHAR_BITS  = 10,
  parameter int unsigned         CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             go_idle,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       id_byte,
  output logic             txd
);

  localparam int unsigned HDR_BITS = BREAK_BITS + 1 + 2 * CHAR_BITS;
  localparam int unsigned VEC_LEN  = 1 << CNT_W;

  logic [VEC_LEN-1:0] hdr_vec;
  logic               txd_q, txd_d;

  // Whole header as a flat vector, one entry per bit time.
  for (genvar g = 0; g < VEC_LEN; g++) begin : g_bit
    if (g < BREAK_BITS) begin : g_brk
      assign hdr_vec[g] = 1'b0;
    end else if (g == BREAK_BITS) begin : g_dlm
      assign hdr_vec[g] = 1'b1;
    end else if (g >= HDR_BITS) begin : g_pad
      assign hdr_vec[g] = 1'b1;
    end else begin : g_chr
      localparam int unsigned POS   = g - BREAK_BITS - 1;
      localparam int unsigned FIELD = POS / CHAR_BITS;
      localparam int unsigned SLOT  = POS % CHAR_BITS;
      if (SLOT == 0) begin : g_start
        assign hdr_vec[g] = 1'b0;
      end else if (SLOT == CHAR_BITS - 1) begin : g_stop
        assign hdr_vec[g] = 1'b1;
      end else if (FIELD == 0) begin : g_sync
        assign hdr_vec[g] = SYNC_CHAR[SLOT-1];
      end else begin : g_id
        assign hdr_vec[g] = id_byte[SLOT-1];
      end
    end
  end

  always_comb begin
    txd_d = txd_q;
    if (shift_en) begin
      txd_d = go_idle ? 1'b1 : hdr_vec[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= txd_d;
    end
  end

  assign txd = txd_q;

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(txd_q));

  assert_first_bit_dominant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !go_idle && idx == '0) |=> !txd_q);

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int unsigned BREAK_BITS = 13,
  parameter logic [7:0]  SYNC_CHAR  = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       id_wr,
  input  logic [7:0] id_data,
  input  logic       cfg_auto_parity,
  input  logic       cfg_irq_en,
  output logic       txd,
  output logic       tx_ready,
  output logic       irq
);

  localparam int unsigned CHAR_BITS = LIN_ID_W + 2;
  localparam int unsigned HDR_BITS  = BREAK_BITS + 1 + 2 * CHAR_BITS;
  localparam int unsigned ID_START  = BREAK_BITS + 1 + CHAR_BITS;
  localparam int unsigned CNT_W     = $clog2(HDR_BITS);

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic                accept, shift_en, go_idle, busy;
  logic [CNT_W-1:0]    nxt_idx;
  logic [LIN_ID_W-1:0] line_id;
  logic [LIN_ID_W-1:0] id_q, id_d;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  lin_id_parity u_parity (
    .raw_id  (id_data),
    .auto_en (cfg_auto_parity),
    .line_id (line_id)
  );

  always_comb begin
    id_d = id_q;
    if (accept) begin
      id_d = line_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      id_q <= '0;
    end else begin
      id_q <= id_d;
    end
  end

  lin_hdr_seq #(
    .TOTAL_BITS (HDR_BITS),
    .ID_START   (ID_START),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .baud_tick (baud_tick),
    .id_wr     (id_wr),
    .accept    (accept),
    .shift_en  (shift_en),
    .go_idle   (go_idle),
    .nxt_idx   (nxt_idx),
    .busy      (busy),
    .tx_ready  (tx_ready)
  );

  lin_hdr_bitgen #(
    .BREAK_BITS (BREAK_BITS),
    .SYNC_CHAR  (SYNC_CHAR),
    .CHAR_BITS  (CHAR_BITS),
    .CNT_W      (CNT_W)
  ) u_bitgen (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (shift_en),
    .go_idle  (go_idle),
    .idx      (nxt_idx),
    .id_byte  (id_q),
    .txd      (txd)
  );

  assign irq = tx_ready & cfg_irq_en;

  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> (txd && tx_ready));

  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy && id_wr) |=> !tx_ready);

  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy && id_wr) |=> $stable(id_q));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cfg_irq_en |-> !irq);

endmodule

// File: tb/lin_hdr_tx_test.sv
module lin_hdr_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       id_wr = 1'b0;
  logic [7:0] id_data = 8'h00;
  logic       cfg_auto_parity = 1'b0;
  logic       cfg_irq_en = 1'b0;
  logic       txd, tx_ready, irq;

  int total = 0;
  int bad = 0;
  int tick_div = 4;
  int tick_cnt = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lin_hdr_tx uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .baud_tick       (baud_tick),
    .id_wr           (id_wr),
    .id_data         (id_data),
    .cfg_auto_parity (cfg_auto_parity),
    .cfg_irq_en      (cfg_irq_en),
    .txd             (txd),
    .tx_ready        (tx_ready),
    .irq             (irq)
  );

  // Baud tick source: one pulse every tick_div cycles.
  always @(posedge clk) begin
    if (tick_cnt + 1 >= tick_div) begin
      tick_cnt  <= 0;
      baud_tick <= 1'b1;
    end else begin
      tick_cnt  <= tick_cnt + 1;
      baud_tick <= 1'b0;
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_state = 0;        // 0 idle, 1 waiting first tick, 2 sending
  int m_pos = 0;
  bit m_txd = 1'b1;
  bit m_ready = 1'b1;
  bit m_bits[$];

  function automatic logic [7:0] exp_id(input logic [7:0] v, input bit ap);
    logic [7:0] r;
    r = v;
    if (ap) begin
      r[6] = v[0] ^ v[1] ^ v[2] ^ v[4];
      r[7] = ~(v[1] ^ v[3] ^ v[4] ^ v[5]);
    end
    return r;
  endfunction

  task automatic build_bits(input logic [7:0] idv);
    m_bits.delete();
    repeat (13) m_bits.push_back(1'b0);
    m_bits.push_back(1'b1);
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(1'(8'h55 >> i));
    m_bits.push_back(1'b1);
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(idv[i]);
    m_bits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_txd = 1'b1; m_ready = 1'b1;
    end else begin
      case (m_state)
        0: if (id_wr) begin
             build_bits(exp_id(id_data, cfg_auto_parity));
             m_state = 1;
             m_ready = 1'b0;
           end
        1: if (baud_tick) begin
             m_state = 2; m_pos = 0; m_txd = m_bits[0];
           end
        default: if (baud_tick) begin
             if (m_pos == 33) begin
               m_state = 0; m_txd = 1'b1;
             end else begin
               m_pos = m_pos + 1;
               m_txd = m_bits[m_pos];
               if (m_pos == 24) m_ready = 1'b1;
             end
           end
      endcase
    end
  end

  function automatic string phase_req();
    if (m_state != 2) return "R1";
    if (m_pos <= 13) return "R2";
    if (m_pos <= 23) return "R3";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare with the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      check(txd == m_txd, phase_req(), "txd vs model (R10)", txd, m_txd);
      check(tx_ready == m_ready, "R6", "tx_ready vs model (R5/R6)", tx_ready, m_ready);
      check(irq == (m_ready && cfg_irq_en), "R7", "irq", irq, m_ready && cfg_irq_en);
    end
  end

  // ---------------- directed headers ----------------
  bit line_log[35];

  task automatic run_header(input logic [7:0] idv, input bit ap, input bit ie,
                            input int div, input int intr_at, input logic [7:0] intr_val);
    int n;
    logic [7:0] got_sync, got_id, want;
    bit brk_ok;
    tick_div        = div;
    cfg_auto_parity = ap;
    cfg_irq_en      = ie;
    repeat (3) @(negedge clk);
    want    = exp_id(idv, ap);
    id_data = idv;
    id_wr   = 1'b1;
    @(negedge clk);
    id_wr   = 1'b0;
    id_data = ~idv;
    check(tx_ready == 1'b0, "R5", "ready cleared after write", tx_ready, 0);
    n = 0;
    while (n < 35) begin
      id_wr = 1'b0;
      if (baud_tick) begin
        line_log[n] = txd;
        if (n == intr_at) begin
          id_data = intr_val;
          id_wr   = 1'b1;
        end
        n++;
      end
      @(negedge clk);
    end
    id_wr = 1'b0;
    check(line_log[0] == 1'b1, "R5", "line idle before first tick", line_log[0], 1);
    brk_ok = 1'b1;
    for (int i = 1; i <= 13; i++) if (line_log[i] != 1'b0) brk_ok = 1'b0;
    check(brk_ok, "R2", "13 dominant break bits", brk_ok, 1);
    check(line_log[14] == 1'b1, "R2", "break delimiter", line_log[14], 1);
    for (int i = 0; i < 8; i++) got_sync[i] = line_log[16 + i];
    check(line_log[15] == 1'b0 && line_log[24] == 1'b1, "R3", "sync framing",
          {line_log[15], line_log[24]}, 2'b01);
    check(got_sync == 8'h55, "R3", "sync byte", got_sync, 8'h55);
    for (int i = 0; i < 8; i++) got_id[i] = line_log[26 + i];
    check(line_log[25] == 1'b0 && line_log[34] == 1'b1, "R4", "id framing",
          {line_log[25], line_log[34]}, 2'b01);
    check(got_id == want, ap ? "R8" : "R4", "identifier byte", got_id, want);
    if (intr_at >= 0)
      check(got_id == want, "R9", "late write ignored", got_id, want);
    repeat (2 * div + 2) @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1, "R10", "line back to idle",
          {txd, tx_ready}, 2'b11);
    check(irq == ie, "R7", "irq after header", irq, ie);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
    check(irq == 1'b0, "R7", "irq masked after reset", irq, 0);
    compare_on = 1'b1;
    run_header(8'h3A, 1'b0, 1'b1, 4, -1, 8'h00);
    run_header(8'h01, 1'b1, 1'b1, 1, -1, 8'h00);     // expect 0xC1
    run_header(8'h00, 1'b1, 1'b0, 3, 5, 8'hFF);      // expect 0x80, write in break
    run_header(8'h3F, 1'b1, 1'b1, 2, 30, 8'h12);     // expect 0xBF, write in id field
    run_header(8'hA5, 1'b0, 1'b0, 5, 34, 8'h77);     // write on final stop tick
    run_header(8'hC4, 1'b1, 1'b1, 1, 20, 8'h3C);
    compare_on = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule